// File: doc/BRIEF.md
# QAM constellation point encoder

This block turns one data word into a single constellation point for a multicarrier transmitter. Each word comes with its own bits-per-point setting b, from 2 to 15. The block returns a signed in-phase coordinate X and a signed quadrature coordinate Y. Both are odd integers. A one-cycle write strobe presents the word, and on the next clock edge the block registers the point and raises a one-cycle valid flag. Words may arrive back to back with no idle cycles.

Even sizes place the point on a square grid. The word's bits alternate between the two axes, and each axis value gets a trailing 1 so it lands on an odd integer. For odd sizes of 5 and up, the low b-1 bits select a point on the square grid for size b-1. When the top bit is set, that point moves out to one of the four arms of a cross. Size 3 uses a small fixed table. Size values 0 and 1 are not legal, and a strobe that carries one is dropped.

Top module: `qam_point_encoder`

## Requirements
- R1: A synchronous, active-high reset drives `pt_x` and `pt_y` to 0 and `pt_valid` to 0 on the next clock edge.
- R2: A strobe with a legal size (2 to 15) in some cycle produces the point on the following clock edge, with `pt_valid` high for exactly that one cycle. Back-to-back strobes each produce one valid cycle, in order.
- R3: For b=2, data values 0, 1, 2 and 3 give (X,Y) = (1,1), (1,-1), (-1,1) and (-1,-1).
- R4: For even b, X is the two's-complement number made from data bits b-1, b-3, ..., 1 (most significant first) followed by a 1. Y is made the same way from bits b-2, ..., 0. Both are sign-extended. For example, with b=4, data 8 gives (-3,1) and data 14 gives (-1,-3).
- R5: For b=3, data values 0 to 7 give (1,1), (1,-1), (-1,1), (-1,-1), (-3,1), (1,3), (-1,-3) and (3,-1).
- R6: For odd b of 5 or more with data bit b-1 clear, the point equals the even-size mapping of bits b-2..0 with size b-1.
- R7: For odd b of 5 or more with data bit b-1 set, start from the square point (X4,Y4) of R6 with M = 2^((b-1)/2). Let h be the bit just below the sign of a coordinate. Let A = M + (coordinate mod M/2). If X4 and Y4 have the same sign, X becomes -A (if X's h is 1) or +A (if it is 0), built from X4, and Y stays Y4. Otherwise Y becomes ±A in the same way, built from Y4, and X stays X4.
- R8: For b=5, data values 16 to 31 give (5,1), (5,3), (-5,1), (-5,3), (1,5), (1,-5), (3,5), (3,-5), (-3,5), (-3,-5), (-1,5), (-1,-5), (5,-3), (5,-1), (-5,-3) and (-5,-1).
- R9: Data bits at position b and above do not affect the point.
- R10: A strobe with size 0 or 1 is ignored. `pt_valid` stays low, and `pt_x` and `pt_y` keep their previous values.
- R11: Every valid point has odd coordinates with magnitude at most 191.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | One-cycle strobe that presents a word |
| bits_sel | input | 4 | Bits per point b for this word |
| word | input | 15 | Data word; the low b bits are used |
| pt_valid | output | 1 | High for one cycle when a new point is out |
| pt_x | output | 9 | Signed in-phase coordinate |
| pt_y | output | 9 | Signed quadrature coordinate |

## Verification
The bench builds the encoder with its default parameters: a 4-bit size field, a 15-bit word and 9-bit coordinates. These defaults reach every legal size from 2 to 15. They include the widest cross at b=15, where arm coordinates reach ±191 and the outermost square points reach ±127. Sizes 2 through 5 are run exhaustively, with junk placed above the active bits. Sizes 6 through 15 are sampled with a pseudo-random word stream that mixes back-to-back strobes with gaps.

// File: rtl/qam_enc_pkg.sv
package qam_enc_pkg;
  localparam int QAM_SIZE_W  = 4;
  localparam int QAM_DATA_W  = 15;
  localparam int QAM_COORD_W = 9;
  localparam int QAM_MIN_B   = 2;
  localparam int QAM_TINY_B  = 3;

  typedef logic signed [QAM_COORD_W-1:0] coord_t;

  typedef struct packed {
    coord_t x;
    coord_t y;
  } point_t;
endpackage

// File: rtl/qam_lattice.sv
// Square grid: deal alternate data bits to X and Y, append a 1, sign-extend.
module qam_lattice #(
  parameter int DATA_W  = 15,
  parameter int COORD_W = 9,
  parameter int HALF_W  = 3
) (
  input  logic [DATA_W-1:0]         data,
  input  logic [HALF_W-1:0]         half,
  output logic signed [COORD_W-1:0] sq_x,
  output logic signed [COORD_W-1:0] sq_y
);
  localparam int PAD_W = 2 * COORD_W;

  logic [PAD_W-1:0] dpad;
  logic             sx;
  logic             sy;

  always_comb begin
    dpad = {{(PAD_W-DATA_W){1'b0}}, data};
    if (half == '0) begin
      sx = 1'b0;
      sy = 1'b0;
    end else begin
      sx = dpad[2*int'(half)-1];
      sy = dpad[2*int'(half)-2];
    end
    sq_x    = '0;
    sq_y    = '0;
    sq_x[0] = 1'b1;
    sq_y[0] = 1'b1;
    for (int i = 1; i < COORD_W; i++) begin
      if (i <= int'(half)) begin
        sq_x[i] = dpad[2*i-1];
        sq_y[i] = dpad[2*i-2];
      end else begin
        sq_x[i] = sx;
        sq_y[i] = sy;
      end
    end
  end
endmodule

// File: rtl/qam_cross_fold.sv
// Moves square points onto the four arms of a cross when the extra top bit is set.
module qam_cross_fold #(
  parameter int COORD_W = 9,
  parameter int HALF_W  = 3
) (
  input  logic signed [COORD_W-1:0] sq_x,
  input  logic signed [COORD_W-1:0] sq_y,
  input  logic [HALF_W-1:0]         half,
  input  logic                      outer,
  output logic signed [COORD_W-1:0] cr_x,
  output logic signed [COORD_W-1:0] cr_y
);
  logic                      sgn_x, sgn_y, hx, hy;
  logic [COORD_W-1:0]        low_mask;
  logic [COORD_W-1:0]        base;
  logic signed [COORD_W-1:0] mag_x, mag_y, arm_x, arm_y;

  always_comb begin
    sgn_x    = sq_x[half];
    sgn_y    = sq_y[half];
    hx       = (half != '0) ? sq_x[half - 1'b1] : 1'b0;
    hy       = (half != '0) ? sq_y[half - 1'b1] : 1'b0;
    low_mask = ~({COORD_W{1'b1}} << (half - 1'b1));
    base     = {{(COORD_W-1){1'b0}}, 1'b1} << half;
    mag_x    = base | (sq_x & low_mask);
    mag_y    = base | (sq_y & low_mask);
    arm_x    = hx ? -mag_x : mag_x;
    arm_y    = hy ? -mag_y : mag_y;
    cr_x     = sq_x;
    cr_y     = sq_y;
    if (outer) begin
      if (sgn_x == sgn_y) cr_x = arm_x;
      else                cr_y = arm_y;
    end
  end
endmodule

// File: rtl/qam_tiny_table.sv
// Fixed eight-point set for three bits per point.
module qam_tiny_table #(
  parameter int COORD_W = 9
) (
  input  logic [2:0]                code,
  output logic signed [COORD_W-1:0] tt_x,
  output logic signed [COORD_W-1:0] tt_y
);
  always_comb begin
    case (code)
      3'd0:    begin tt_x =  COORD_W'(1); tt_y =  COORD_W'(1); end
      3'd1:    begin tt_x =  COORD_W'(1); tt_y = -COORD_W'(1); end
      3'd2:    begin tt_x = -COORD_W'(1); tt_y =  COORD_W'(1); end
      3'd3:    begin tt_x = -COORD_W'(1); tt_y = -COORD_W'(1); end
      3'd4:    begin tt_x = -COORD_W'(3); tt_y =  COORD_W'(1); end
      3'd5:    begin tt_x =  COORD_W'(1); tt_y =  COORD_W'(3); end
      3'd6:    begin tt_x = -COORD_W'(1); tt_y = -COORD_W'(3); end
      default: begin tt_x =  COORD_W'(3); tt_y = -COORD_W'(1); end
    endcase
  end
endmodule

// File: rtl/qam_point_encoder.sv
module qam_point_encoder
  import qam_enc_pkg::*;
#(
  parameter int SIZE_W  = QAM_SIZE_W,
  parameter int DATA_W  = QAM_DATA_W,
  parameter int COORD_W = QAM_COORD_W,
  parameter int MIN_B   = QAM_MIN_B,
  parameter int TINY_B  = QAM_TINY_B
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [SIZE_W-1:0]         bits_sel,
  input  logic [DATA_W-1:0]         word,
  output logic                      pt_valid,
  output logic signed [COORD_W-1:0] pt_x,
  output logic signed [COORD_W-1:0] pt_y
);
  localparam int HALF_W = $clog2(DATA_W/2 + 1);

  logic                      legal;
  logic                      is_odd;
  logic                      outer;
  logic [DATA_W-1:0]         word_m;
  logic [SIZE_W-1:0]         even_sz;
  logic [HALF_W-1:0]         half;
  logic signed [COORD_W-1:0] sq_x, sq_y, cr_x, cr_y, tt_x, tt_y, nx_x, nx_y;

  always_comb begin
    legal   = (bits_sel >= SIZE_W'(MIN_B));
    is_odd  = bits_sel[0];
    word_m  = word & ~({DATA_W{1'b1}} << bits_sel);
    even_sz = bits_sel - {{(SIZE_W-1){1'b0}}, is_odd};
    half    = HALF_W'(even_sz >> 1);
    outer   = ((word_m >> (bits_sel - 1'b1)) != '0);
  end

  qam_lattice #(.DATA_W(DATA_W), .COORD_W(COORD_W), .HALF_W(HALF_W)) u_lattice (
    .data (word_m),
    .half (half),
    .sq_x (sq_x),
    .sq_y (sq_y)
  );

  qam_cross_fold #(.COORD_W(COORD_W), .HALF_W(HALF_W)) u_fold (
    .sq_x  (sq_x),
    .sq_y  (sq_y),
    .half  (half),
    .outer (outer),
    .cr_x  (cr_x),
    .cr_y  (cr_y)
  );

  qam_tiny_table #(.COORD_W(COORD_W)) u_tiny (
    .code (word_m[2:0]),
    .tt_x (tt_x),
    .tt_y (tt_y)
  );

  always_comb begin
    if (bits_sel == SIZE_W'(TINY_B)) begin
      nx_x = tt_x;
      nx_y = tt_y;
    end else if (is_odd) begin
      nx_x = cr_x;
      nx_y = cr_y;
    end else begin
      nx_x = sq_x;
      nx_y = sq_y;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pt_valid <= 1'b0;
      pt_x     <= '0;
      pt_y     <= '0;
    end else begin
      pt_valid <= wr_en && legal;
      if (wr_en && legal) begin
        pt_x <= nx_x;
        pt_y <= nx_y;
      end
    end
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!pt_valid && pt_x == '0 && pt_y == '0));

  a_r2_strobe_gives_valid: assert property (@(posedge clk) disable iff (rst)
    (wr_en && legal) |=> pt_valid);

  a_r2_valid_one_cycle: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> !pt_valid);

  a_r10_illegal_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !legal) |=> (!pt_valid && $stable(pt_x) && $stable(pt_y)));

  a_r11_odd_coords: assert property (@(posedge clk) disable iff (rst)
    pt_valid |-> (pt_x[0] && pt_y[0]));
endmodule

// File: tb/tb_qam_point_encoder.sv
module tb_qam_point_encoder;
  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [3:0]        bits_sel = '0;
  logic [14:0]       word = '0;
  logic              pt_valid;
  logic signed [8:0] pt_x, pt_y;

  int total = 0;
  int bad = 0;
  int n_sent = 0;
  int n_seen = 0;
  int q_x[$];
  int q_y[$];
  string q_tag[$];
  int unsigned seed = 32'h1234_5678;

  qam_point_encoder dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .bits_sel(bits_sel), .word(word),
    .pt_valid(pt_valid), .pt_x(pt_x), .pt_y(pt_y)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // Independent model built from the requirement text.
  function automatic void ref_point(input int size, input int data,
                                    output int rx, output int ry);
    int d, p, half, ux, uy, vx, vy, m, h, lowv, mag;
    bit sx, sy;
    d = data & ((1 << size) - 1);
    if (size == 3) begin
      case (d)
        0: begin rx = 1;  ry = 1;  end
        1: begin rx = 1;  ry = -1; end
        2: begin rx = -1; ry = 1;  end
        3: begin rx = -1; ry = -1; end
        4: begin rx = -3; ry = 1;  end
        5: begin rx = 1;  ry = 3;  end
        6: begin rx = -1; ry = -3; end
        default: begin rx = 3; ry = -1; end
      endcase
      return;
    end
    p = size - (size % 2);
    half = p / 2;
    ux = 0; uy = 0;
    for (int j = 0; j < half; j++) begin
      ux = ux | (((d >> (2*j+1)) & 1) << j);
      uy = uy | (((d >> (2*j)) & 1) << j);
    end
    vx = (ux >= (1 << (half-1))) ? ux - (1 << half) : ux;
    vy = (uy >= (1 << (half-1))) ? uy - (1 << half) : uy;
    rx = 2*vx + 1;
    ry = 2*vy + 1;
    if ((size % 2) == 1 && ((d >> (size-1)) & 1) == 1) begin
      m = 1 << half;
      sx = (rx < 0);
      sy = (ry < 0);
      if (sx == sy) begin
        h = (rx > 0) ? (rx >= m/2) : (rx > -m/2);
        lowv = ((rx % (m/2)) + m/2) % (m/2);
        mag = m + lowv;
        rx = h ? -mag : mag;
      end else begin
        h = (ry > 0) ? (ry >= m/2) : (ry > -m/2);
        lowv = ((ry % (m/2)) + m/2) % (m/2);
        mag = m + lowv;
        ry = h ? -mag : mag;
      end
    end
  endfunction

  task automatic send_exp(input int size, input int data, input int ex,
                          input int ey, input string tag);
    @(negedge clk);
    bits_sel = 4'(size);
    word = 15'(data);
    wr_en = 1'b1;
    q_x.push_back(ex);
    q_y.push_back(ey);
    q_tag.push_back(tag);
    n_sent++;
  endtask

  task automatic send_ref(input int size, input int data, input string tag);
    int ex, ey;
    ref_point(size, data, ex, ey);
    send_exp(size, data, ex, ey, tag);
  endtask

  task automatic idle();
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic string kind_tag(input int size, input int data);
    if (size == 3) return "R5";
    if ((size % 2) == 0) return "R4";
    if (((data >> (size-1)) & 1) == 1) return "R7";
    return "R6";
  endfunction

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && pt_valid) begin
      n_seen++;
      if (q_x.size() == 0) begin
        check(1'b0, "R2", "unexpected valid", 1, 0);
      end else begin
        int ex, ey;
        string tg;
        ex = q_x.pop_front();
        ey = q_y.pop_front();
        tg = q_tag.pop_front();
        check(int'(pt_x) == ex, tg, "x", int'(pt_x), ex);
        check(int'(pt_y) == ey, tg, "y", int'(pt_y), ey);
        check(pt_x[0] && pt_y[0] && int'(pt_x) <= 191 && int'(pt_x) >= -191 &&
              int'(pt_y) <= 191 && int'(pt_y) >= -191, "R11", "odd/range x",
              int'(pt_x), ex);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R2 watchdog actual=%0d expected=%0d", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int hold_x, hold_y, cnt;
    repeat (2) @(negedge clk);
    check(pt_valid == 1'b0, "R1", "valid in reset", int'(pt_valid), 0);
    check(pt_x == 0 && pt_y == 0, "R1", "x in reset", int'(pt_x), 0);
    rst = 1'b0;

    // R3 literal, back to back
    send_exp(2, 0, 1, 1, "R3");
    send_exp(2, 1, 1, -1, "R3");
    send_exp(2, 2, -1, 1, "R3");
    send_exp(2, 3, -1, -1, "R3");
    // R4 literal
    send_exp(4, 8, -3, 1, "R4");
    send_exp(4, 14, -1, -3, "R4");
    send_exp(4, 4, 1, -3, "R4");
    // R5 full table
    send_exp(3, 0, 1, 1, "R5");
    send_exp(3, 4, -3, 1, "R5");
    send_exp(3, 5, 1, 3, "R5");
    send_exp(3, 6, -1, -3, "R5");
    send_exp(3, 7, 3, -1, "R5");
    idle();
    // R8 literal cross points
    send_exp(5, 16, 5, 1, "R8");
    send_exp(5, 19, -5, 3, "R8");
    send_exp(5, 21, 1, -5, "R8");
    send_exp(5, 24, -3, 5, "R8");
    send_exp(5, 29, 5, -1, "R8");
    send_exp(5, 31, -5, -1, "R8");
    send_exp(5, 4, 1, -3, "R6");
    idle();

    // Exhaustive small sizes with gaps
    for (int s = 2; s <= 5; s++) begin
      for (int v = 0; v < (1 << s); v++) begin
        send_ref(s, v, kind_tag(s, v));
        if ((v % 5) == 4) idle();
      end
    end
    idle();

    // R9: junk above the active bits
    for (int s = 2; s <= 14; s++) begin
      for (int k = 0; k < 4; k++) begin
        int v;
        seed = seed * 1103515245 + 12345;
        v = int'((seed >> 8) & 32'h7fff) | (1 << s);
        send_ref(s, v, "R9");
      end
    end
    idle();

    // Larger sizes, sampled
    for (int s = 6; s <= 15; s++) begin
      for (int k = 0; k < 40; k++) begin
        int v;
        seed = seed * 1103515245 + 12345;
        v = int'((seed >> 8) & 32'h7fff);
        send_ref(s, v, kind_tag(s, v & ((1 << s) - 1)));
        if ((k % 7) == 6) idle();
      end
    end
    idle();

    // R2: isolated word, valid lasts one cycle
    send_exp(4, 3, 3, 3, "R2");
    idle();
    check(pt_valid == 1'b1, "R2", "valid after strobe", int'(pt_valid), 1);
    @(negedge clk);
    check(pt_valid == 1'b0, "R2", "valid one cycle", int'(pt_valid), 0);

    // R10: illegal sizes
    hold_x = int'(pt_x);
    hold_y = int'(pt_y);
    for (int s = 0; s <= 1; s++) begin
      @(negedge clk);
      bits_sel = 4'(s);
      word = 15'h7fff;
      wr_en = 1'b1;
      @(negedge clk);
      check(pt_valid == 1'b0, "R10", "valid on illegal size", int'(pt_valid), 0);
      check(int'(pt_x) == hold_x && int'(pt_y) == hold_y, "R10", "x held",
            int'(pt_x), hold_x);
      wr_en = 1'b0;
    end
    @(negedge clk);
    check(pt_valid == 1'b0, "R10", "valid after illegal", int'(pt_valid), 0);

    // R1: reset in mid-run
    send_exp(5, 16, 5, 1, "R8");
    idle();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(pt_valid == 1'b0 && pt_x == 0 && pt_y == 0, "R1", "cleared x",
          int'(pt_x), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    cnt = q_x.size();
    check(cnt == 0, "R2", "pending points", cnt, 0);
    check(n_seen == n_sent, "R2", "valid count", n_seen, n_sent);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule